// File: doc/BRIEF.md
# Mode-Controlled Addressable Eight-Bit Output Register

This block holds a bank of output bits, eight by default, and writes them one bit at a time. A binary address picks one bit and a single data input gives its new value. Two active-low controls pick one of four modes. In demultiplex mode the addressed bit takes the data and every other bit is driven low. In addressable-write mode the addressed bit takes the data and every other bit keeps its value. Hold mode freezes the whole bank. Clear mode zeroes the whole bank.

The block is synchronous. All inputs are sampled on the rising edge of the clock and the outputs come straight from flip-flops. A separate system reset zeroes the bank whatever the mode controls are doing. A parameter chooses whether that reset acts at the clock edge or at once.

Top module: `addr_latch_bank`

## Requirements
- R1: Outputs change only at a rising clock edge. A change applied to any input between two edges leaves `q_o` unchanged until the next edge, and that edge applies the mode that was sampled there.
- R2: When `gate_n_i`=0 and `clr_n_i`=0 (demultiplex), the edge sets `q_o[addr_i]` to `data_i` and sets every other bit of `q_o` to 0.
- R3: When `gate_n_i`=0 and `clr_n_i`=1 (addressable write), the edge sets `q_o[addr_i]` to `data_i` and every other bit of `q_o` keeps its value.
- R4: When `gate_n_i`=1 and `clr_n_i`=1 (hold), the edge leaves every bit of `q_o` unchanged, whatever the values of `addr_i` and `data_i`.
- R5: When `gate_n_i`=1 and `clr_n_i`=0 (clear), the edge sets all of `q_o` to 0, whatever the values of `addr_i` and `data_i`.
- R6: While `rst_n` is low, `q_o` is all zeros whatever the mode controls are. With `ASYNC_RST`=0 this takes effect at the next edge. With `ASYNC_RST`=1 it takes effect at once.
- R7: A series of addressable writes to different addresses changes only the bit addressed at each edge. Bits written earlier keep their last written value.
- R8: The address is an unsigned binary number. An address value of k selects `q_o[k]`, where bit 0 is the least significant output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low system reset; zeroes all outputs |
| addr_i | input | ADDR_W (3) | Binary index of the target output bit |
| data_i | input | 1 | Value written to the addressed bit |
| gate_n_i | input | 1 | Active-low write gate; low lets data reach the addressed bit |
| clr_n_i | input | 1 | Active-low clear; low zeroes the bits that are not being written |
| q_o | output | NUM_BITS (8) | Registered output bank |

## Verification
The case that is hardest to reach from the ports is a mode that must leave a bank untouched while that bank holds a varied mixture of ones and zeros. Only then does a wrong bit that is held, cleared or written show up. The stimulus therefore loads a distinct pattern through addressable writes before each directed sweep of the four modes over every address and both data values. It then runs a long seeded random sequence that is weighted toward addressable writes, so that the bank stays dense while hold, clear and demultiplex edges arrive in between.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

   typedef enum logic [1:0] {
      MODE_DEMUX = 2'b00,
      MODE_WRITE = 2'b01,
      MODE_CLEAR = 2'b10,
      MODE_HOLD  = 2'b11
   } bank_mode_e;

   function automatic bank_mode_e mode_of(input logic gate_n, input logic clr_n);
      return bank_mode_e'({gate_n, clr_n});
   endfunction

endpackage

// File: rtl/addr_latch_mode_dec.sv
module addr_latch_mode_dec
   import addr_latch_pkg::*;
(
   input  logic       gate_n_i,
   input  logic       clr_n_i,
   output bank_mode_e mode_o,
   output logic       wr_sel_o,
   output logic       clr_rest_o
);

   always_comb begin
      mode_o     = mode_of(gate_n_i, clr_n_i);
      wr_sel_o   = 1'b0;
      clr_rest_o = 1'b0;
      unique case (mode_o)
         MODE_DEMUX: begin wr_sel_o = 1'b1; clr_rest_o = 1'b1; end
         MODE_WRITE: begin wr_sel_o = 1'b1; clr_rest_o = 1'b0; end
         MODE_CLEAR: begin wr_sel_o = 1'b0; clr_rest_o = 1'b1; end
         default:    begin wr_sel_o = 1'b0; clr_rest_o = 1'b0; end
      endcase
   end

endmodule

// File: rtl/addr_latch_addr_dec.sv
module addr_latch_addr_dec #(
   parameter int NUM_BITS = 8,
   parameter int ADDR_W   = 3
) (
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                en_i,
   output logic [NUM_BITS-1:0] sel_o
);

   if (NUM_BITS > (1 << ADDR_W)) begin : g_bad_width
      $error("addr_latch_addr_dec: address too narrow for NUM_BITS");
   end

   for (genvar k = 0; k < NUM_BITS; k++) begin : g_sel
      assign sel_o[k] = en_i && (addr_i == ADDR_W'(k));
   end

endmodule

// File: rtl/addr_latch_cell.sv
module addr_latch_cell #(
   parameter bit ASYNC_RST = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic clr_i,
   input  logic data_i,
   output logic q_o
);

   logic nxt;

   always_comb begin
      if (sel_i)      nxt = data_i;
      else if (clr_i) nxt = 1'b0;
      else            nxt = q_o;
   end

   if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o <= 1'b0;
         else        q_o <= nxt;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) q_o <= 1'b0;
         else        q_o <= nxt;
      end
   end

endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
   import addr_latch_pkg::*;
#(
   parameter int NUM_BITS  = 8,
   parameter bit ASYNC_RST = 1'b0,
   localparam int ADDR_W   = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                data_i,
   input  logic                gate_n_i,
   input  logic                clr_n_i,
   output logic [NUM_BITS-1:0] q_o
);

   if (NUM_BITS < 2) begin : g_bad_bits
      $error("addr_latch_bank: NUM_BITS must be at least 2");
   end

   bank_mode_e          mode;
   logic                wr_sel;
   logic                clr_rest;
   logic [NUM_BITS-1:0] sel;

   addr_latch_mode_dec u_mode (
      .gate_n_i  (gate_n_i),
      .clr_n_i   (clr_n_i),
      .mode_o    (mode),
      .wr_sel_o  (wr_sel),
      .clr_rest_o(clr_rest)
   );

   addr_latch_addr_dec #(.NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W)) u_addr (
      .addr_i(addr_i),
      .en_i  (wr_sel),
      .sel_o (sel)
   );

   for (genvar k = 0; k < NUM_BITS; k++) begin : g_cell
      addr_latch_cell #(.ASYNC_RST(ASYNC_RST)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .sel_i (sel[k]),
         .clr_i (clr_rest),
         .data_i(data_i),
         .q_o   (q_o[k])
      );
   end

   // R2: non-addressed bits go low in demultiplex mode
   a_r2_demux_rest_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DEMUX) |=> ((q_o & ~$past(sel)) == '0));

   // R2/R3/R8: the addressed bit takes the data
   a_r8_addr_bit_written: assert property (@(posedge clk) disable iff (!rst_n)
      ((!gate_n_i) && (32'(addr_i) < NUM_BITS)) |=> (q_o[$past(addr_i)] == $past(data_i)));

   // R3/R7: non-addressed bits keep their value in addressable write mode
   a_r3_write_rest_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_WRITE) |=> ((q_o & ~$past(sel)) == ($past(q_o) & ~$past(sel))));

   // R4: hold freezes the bank
   a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_n_i && clr_n_i) |=> $stable(q_o));

   // R5: clear zeroes the bank
   a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_n_i && !clr_n_i) |=> (q_o == '0));

   // R2/R3: at most one bit is selected for writing
   a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

endmodule

// File: tb/addr_latch_bank_tb.sv
`timescale 1ns/1ps
module addr_latch_bank_tb;

   localparam int NB = 8;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          data = 1'b0;
   logic          gate_n = 1'b1;
   logic          clr_n = 1'b1;
   logic [NB-1:0] q;
   logic [NB-1:0] exp_q = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   addr_latch_bank #(.NUM_BITS(NB), .ASYNC_RST(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .data_i(data),
      .gate_n_i(gate_n), .clr_n_i(clr_n), .q_o(q)
   );

   function automatic logic [NB-1:0] model(input logic [NB-1:0] cur,
      input logic g, input logic c, input logic [AW-1:0] a, input logic d);
      logic [NB-1:0] r;
      r = cur;
      if (!g && !c) begin r = '0; r[a] = d; end
      else if (!g && c) r[a] = d;
      else if (g && !c) r = '0;
      return r;
   endfunction

   function automatic string tag_of(input logic g, input logic c);
      if (!g && !c) return "R2";
      if (!g && c)  return "R3";
      if (g && c)   return "R4";
      return "R5";
   endfunction

   task automatic check(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: q_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // drive at the falling edge, sample 1 ns after the next rising edge
   task automatic step(input logic g, input logic c, input logic [AW-1:0] a, input logic d);
      @(negedge clk);
      gate_n = g; clr_n = c; addr = a; data = d;
      @(posedge clk);
      exp_q = model(exp_q, g, c, a, d);
      #1;
      check(tag_of(g, c), q, exp_q);
   endtask

   task automatic load(input logic [NB-1:0] pat);
      for (int k = 0; k < NB; k++) step(1'b0, 1'b1, AW'(k), pat[k]);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: q_o=%b expected completion", q);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [NB-1:0] held;
      void'($urandom(32'd1234));
      // R6: reset clears regardless of controls
      gate_n = 1'b0; clr_n = 1'b1; data = 1'b1; addr = 3'd5;
      repeat (3) @(posedge clk);
      #1 check("R6", q, '0);
      @(negedge clk); gate_n = 1'b1; clr_n = 1'b1; rst_n = 1'b1;
      @(posedge clk); #1 check("R6", q, '0);

      // R8: address k selects bit k
      for (int k = 0; k < NB; k++) begin
         step(1'b0, 1'b0, AW'(k), 1'b1);
         check("R8", q, NB'(1) << k);
      end

      // full sweep: each mode, each address, both data values, on a loaded bank
      for (int m = 0; m < 4; m++)
         for (int k = 0; k < NB; k++)
            for (int d = 0; d < 2; d++) begin
               load(8'hA5 ^ NB'(k * 37 + d));
               step(m[1], m[0], AW'(k), d[0]);
            end

      // R7: successive writes leave earlier bits alone
      step(1'b1, 1'b0, 3'd0, 1'b0);
      step(1'b0, 1'b1, 3'd1, 1'b1);
      step(1'b0, 1'b1, 3'd6, 1'b1);
      step(1'b0, 1'b1, 3'd3, 1'b1);
      step(1'b0, 1'b1, 3'd6, 1'b0);
      check("R7", q, 8'b0000_1010);

      // R4/R5: address and data churn in hold and clear modes
      load(8'h3C);
      for (int k = 0; k < NB; k++) step(1'b1, 1'b1, AW'(k), k[0]);
      check("R4", q, 8'h3C);
      step(1'b1, 1'b0, 3'd7, 1'b1);
      check("R5", q, 8'h00);

      // R1: input changes between edges do not reach the outputs
      load(8'h96);
      @(negedge clk);
      held = q;
      gate_n = 1'b0; clr_n = 1'b0; addr = 3'd0; data = 1'b1;
      #2 check("R1", q, held);
      gate_n = 1'b1; clr_n = 1'b0;
      #2 check("R1", q, held);
      @(posedge clk); exp_q = '0; #1 check("R1", q, exp_q);

      // R6: reset mid-run overrides an addressable write
      load(8'hFF);
      @(negedge clk); rst_n = 1'b0; gate_n = 1'b0; clr_n = 1'b1; addr = 3'd2; data = 1'b1;
      @(posedge clk); #1 check("R6", q, '0);
      @(negedge clk); rst_n = 1'b1; gate_n = 1'b1; clr_n = 1'b1;
      exp_q = '0;

      // random run weighted toward addressable writes
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic g, c;
         r = $urandom_range(0, 9);
         if (r < 5)      begin g = 1'b0; c = 1'b1; end
         else if (r < 7) begin g = 1'b1; c = 1'b1; end
         else if (r < 9) begin g = 1'b0; c = 1'b0; end
         else            begin g = 1'b1; c = 1'b0; end
         step(g, c, AW'($urandom_range(0, NB - 1)), 1'($urandom_range(0, 1)));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule